// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-side data cache built from a direct-mapped line array and a small, fully associative buffer of lines recently pushed out of that array. A lookup that hits the main array answers on the next cycle, exactly as a plain direct-mapped cache would. A lookup that misses there spends one extra cycle probing the side buffer. If the line is found, the buffered line and the conflicting main-array line trade places in one step. Only when both structures miss does the block issue a request on its memory port. It then stalls until the memory answers.

A memory fill always lands in the main array. If the line it replaces was valid, that line is written into the side buffer at a rotating first-in-first-out pointer, which overwrites the oldest insertion. Every buffer entry keeps the complete line address, so lines from any set can be held side by side. Each line holds one data word. Addresses are line addresses: the low `IDX_W` bits pick the set and the remaining bits form the tag.

Top module: `vcache_top`

## Requirements
- R1: After reset no line is valid in either structure, `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and the first access to any address is served from memory.
- R2: A request accepted while the main array holds its line produces `resp_valid` on the following cycle with `resp_src` = 2'b00 and the stored data, with no memory request.
- R3: On a main-array miss the side buffer is probed in the next cycle, before any memory request. A buffer hit returns `resp_src` = 2'b01 two cycles after acceptance, with no memory request. `resp_src` never takes the value 2'b11.
- R4: On a buffer hit the requested line moves into the main array and the displaced main line moves into the same buffer entry. The next access to the requested line is a main hit, and the next access to the displaced line is a buffer hit.
- R5: When both miss, `mem_req_valid` rises with `mem_req_addr` equal to the requested line address. Both stay steady until `mem_resp_valid`. The response follows one cycle later with `resp_src` = 2'b10 and the memory data.
- R6: A fill that replaces a valid main line inserts that line into the buffer at a rotating pointer. After `VICT_N` further insertions, that line is lost and is served from memory again.
- R7: A fill into a set whose main line is invalid inserts nothing into the buffer and does not move the pointer.
- R8: `req_ready` is 0 from acceptance of a missing request until its response cycle, and no memory request is pending while `req_ready` is 1.
- R9: A buffer entry matches only on the full line address. Lines from different sets coexist in the buffer, and at most one entry matches any address.
- R10: A new request may be accepted in the same cycle that the previous response is visible, and its lookup sees the line that the previous fill or swap just wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | LINE_W | Requested line address |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_data | output | DATA_W | Returned line data |
| resp_src | output | 2 | 00 main hit, 01 buffer hit, 10 memory |
| mem_req_valid | output | 1 | Memory read pending |
| mem_req_addr | output | LINE_W | Line address sent to memory |
| mem_resp_valid | input | 1 | Memory data strobe |
| mem_resp_data | input | DATA_W | Memory line data |

## Verification
Two things can happen in the same cycle. A response can be visible while the next request is accepted, and that lookup reads a set that the just-finished fill or swap rewrote. The bench drives each new request at the same falling edge where it sees the previous response. An access repeated at once after a memory fill must hit the main array. A line swapped out must come back from the buffer with the correct data. A reference model of sets, buffer contents and pointer predicts every source code, data word and latency over directed sweeps and a long pseudo-random address stream.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_VPROBE  = 2'd1,
    ST_MEMWAIT = 2'd2
  } vc_state_e;

  localparam logic [1:0] SRC_MAIN = 2'b00;
  localparam logic [1:0] SRC_VICT = 2'b01;
  localparam logic [1:0] SRC_MEM  = 2'b10;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   val_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  // valid bits are the only reset state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (wr_en) begin
      val_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = val_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];
endmodule

// File: rtl/vc_victim_store.sv
module vc_victim_store #(
  parameter int LINE_W  = 6,
  parameter int DATA_W  = 16,
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_W-1:0]  lk_addr,
  output logic               hit,
  output logic [DATA_W-1:0]  hit_data,
  output logic [ENTRIES-1:0] match_vec,
  input  logic               swap_en,
  input  logic               ins_en,
  input  logic               wr_valid,
  input  logic [LINE_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] val_q;
  logic [LINE_W-1:0]  adr_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [PTR_W-1:0]   hit_slot, wr_slot;
  logic               we;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign match_vec[g] = val_q[g] && (adr_q[g] == lk_addr);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q[g] <= 1'b0;
        end else if (we && (wr_slot == PTR_W'(g))) begin
          val_q[g] <= wr_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (we && (wr_slot == PTR_W'(g))) begin
          adr_q[g] <= wr_addr;
          dat_q[g] <= wr_data;
        end
      end
    end
  endgenerate

  always_comb begin
    hit_slot = '0;
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_slot = PTR_W'(i);
        hit_data = hit_data | dat_q[i];
      end
    end
  end

  assign hit     = |match_vec;
  assign we      = swap_en | ins_en;
  assign wr_slot = swap_en ? hit_slot : ptr_q;
  assign ptr_d   = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ins_en) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
#(
  parameter int LINE_W = 6,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  localparam int TAG_W = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_src,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data,
  output logic [LINE_W-1:0] lk_addr,
  input  logic              main_valid,
  input  logic [TAG_W-1:0]  main_tag,
  input  logic [DATA_W-1:0] main_data,
  output logic              main_hit,
  output logic              main_we,
  output logic [IDX_W-1:0]  main_widx,
  output logic [TAG_W-1:0]  main_wtag,
  output logic [DATA_W-1:0] main_wdata,
  input  logic              vict_hit,
  input  logic [DATA_W-1:0] vict_data,
  output logic              vic_swap,
  output logic              vic_ins,
  output logic              vic_wvalid,
  output logic [LINE_W-1:0] vic_waddr,
  output logic [DATA_W-1:0] vic_wdata
);
  vc_state_e         state_q, state_d;
  logic [LINE_W-1:0] addr_q;
  logic              addr_en;
  logic              resp_vld_q, resp_vld_d;
  logic [DATA_W-1:0] resp_dat_q, resp_dat_d;
  logic [1:0]        resp_src_q, resp_src_d;

  assign lk_addr  = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign main_hit = main_valid && (main_tag == lk_addr[LINE_W-1:IDX_W]);

  always_comb begin
    state_d    = state_q;
    addr_en    = 1'b0;
    resp_vld_d = 1'b0;
    resp_dat_d = resp_dat_q;
    resp_src_d = resp_src_q;
    main_we    = 1'b0;
    main_wdata = mem_resp_data;
    vic_swap   = 1'b0;
    vic_ins    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (main_hit) begin
            resp_vld_d = 1'b1;
            resp_dat_d = main_data;
            resp_src_d = SRC_MAIN;
          end else begin
            addr_en = 1'b1;
            state_d = ST_VPROBE;
          end
        end
      end
      ST_VPROBE: begin
        if (vict_hit) begin
          main_we    = 1'b1;
          main_wdata = vict_data;
          vic_swap   = 1'b1;
          resp_vld_d = 1'b1;
          resp_dat_d = vict_data;
          resp_src_d = SRC_VICT;
          state_d    = ST_IDLE;
        end else begin
          state_d = ST_MEMWAIT;
        end
      end
      ST_MEMWAIT: begin
        if (mem_resp_valid) begin
          main_we    = 1'b1;
          vic_ins    = main_valid;
          resp_vld_d = 1'b1;
          resp_dat_d = mem_resp_data;
          resp_src_d = SRC_MEM;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      resp_vld_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      resp_vld_q <= resp_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) begin
      addr_q <= req_addr;
    end
    if (resp_vld_d) begin
      resp_dat_q <= resp_dat_d;
      resp_src_q <= resp_src_d;
    end
  end

  assign main_widx     = addr_q[IDX_W-1:0];
  assign main_wtag     = addr_q[LINE_W-1:IDX_W];
  assign vic_wvalid    = main_valid;
  assign vic_waddr     = {main_tag, addr_q[IDX_W-1:0]};
  assign vic_wdata     = main_data;
  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_MEMWAIT);
  assign mem_req_addr  = addr_q;
  assign resp_valid    = resp_vld_q;
  assign resp_data     = resp_dat_q;
  assign resp_src      = resp_src_q;
endmodule

// File: rtl/vcache_top.sv
module vcache_top #(
  parameter int LINE_W = 6,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  parameter int VICT_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_src,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data
);
  localparam int TAG_W = LINE_W - IDX_W;

  logic [LINE_W-1:0] lk_addr;
  logic              main_valid, main_hit, main_we;
  logic [TAG_W-1:0]  main_tag, main_wtag;
  logic [DATA_W-1:0] main_data, main_wdata;
  logic [IDX_W-1:0]  main_widx;
  logic              vict_hit, vic_swap, vic_ins, vic_wvalid;
  logic [DATA_W-1:0] vict_data, vic_wdata;
  logic [LINE_W-1:0] vic_waddr;
  logic [VICT_N-1:0] vict_match;

  vc_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_main (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_addr[IDX_W-1:0]), .rd_valid(main_valid), .rd_tag(main_tag), .rd_data(main_data),
    .wr_en(main_we), .wr_idx(main_widx), .wr_tag(main_wtag), .wr_data(main_wdata)
  );

  vc_victim_store #(.LINE_W(LINE_W), .DATA_W(DATA_W), .ENTRIES(VICT_N)) u_vict (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
    .hit(vict_hit), .hit_data(vict_data), .match_vec(vict_match),
    .swap_en(vic_swap), .ins_en(vic_ins), .wr_valid(vic_wvalid),
    .wr_addr(vic_waddr), .wr_data(vic_wdata)
  );

  vc_ctrl #(.LINE_W(LINE_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_src(resp_src),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .lk_addr(lk_addr), .main_valid(main_valid), .main_tag(main_tag), .main_data(main_data),
    .main_hit(main_hit), .main_we(main_we), .main_widx(main_widx), .main_wtag(main_wtag),
    .main_wdata(main_wdata), .vict_hit(vict_hit), .vict_data(vict_data),
    .vic_swap(vic_swap), .vic_ins(vic_ins), .vic_wvalid(vic_wvalid),
    .vic_waddr(vic_waddr), .vic_wdata(vic_wdata)
  );
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int LINE_W = 6,
  parameter int VICT_N = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              main_hit,
  input logic              resp_valid,
  input logic [1:0]        resp_src,
  input logic              mem_req_valid,
  input logic [LINE_W-1:0] mem_req_addr,
  input logic              mem_resp_valid,
  input logic [VICT_N-1:0] vict_match
);
  p_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && main_hit |=> resp_valid && resp_src == 2'b00);

  p_probe_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(!req_ready));

  p_src_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_src != 2'b11);

  p_memreq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr));

  p_fill_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_resp_valid |=> resp_valid && resp_src == 2'b10 && req_ready);

  p_idle_nomem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vict_match));
endmodule

bind vcache_top vc_checker #(.LINE_W(LINE_W), .VICT_N(VICT_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .main_hit(main_hit), .resp_valid(resp_valid), .resp_src(resp_src),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_resp_valid(mem_resp_valid), .vict_match(vict_match)
);

// File: tb/vcache_top_test.sv
`timescale 1ns/1ps
module vcache_top_test;
  localparam int LINE_W  = 6;
  localparam int IDX_W   = 3;
  localparam int DATA_W  = 16;
  localparam int VICT_N  = 4;
  localparam int SETS    = 1 << IDX_W;
  localparam int MEM_LAT = 3;

  logic              clk, rst_n;
  logic              req_valid;
  logic [LINE_W-1:0] req_addr;
  logic              req_ready, resp_valid;
  logic [DATA_W-1:0] resp_data;
  logic [1:0]        resp_src;
  logic              mem_req_valid;
  logic [LINE_W-1:0] mem_req_addr;
  logic              mem_resp_valid;
  logic [DATA_W-1:0] mem_resp_data;

  int checks, failures, mem_cnt;
  logic [LINE_W-1:0] mem_last;

  // reference model
  bit              mv [SETS];
  bit [LINE_W-IDX_W-1:0] mt [SETS];
  bit              vv [VICT_N];
  bit [LINE_W-1:0] va [VICT_N];
  int              vp;

  vcache_top #(.LINE_W(LINE_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .VICT_N(VICT_N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_src(resp_src), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] memfn(input logic [LINE_W-1:0] a);
    return DATA_W'(a) * 16'd37 + 16'h1234;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < SETS; i++) begin mv[i] = 0; mt[i] = '0; end
    for (int k = 0; k < VICT_N; k++) begin vv[k] = 0; va[k] = '0; end
    vp = 0;
  endtask

  function automatic int predict(input logic [LINE_W-1:0] a);
    int idx;
    bit [LINE_W-IDX_W-1:0] tg;
    idx = int'(a[IDX_W-1:0]);
    tg  = a[LINE_W-1:IDX_W];
    if (mv[idx] && mt[idx] == tg) return 0;
    for (int k = 0; k < VICT_N; k++) begin
      if (vv[k] && va[k] == a) begin
        va[k] = {mt[idx], a[IDX_W-1:0]};
        vv[k] = mv[idx];
        mv[idx] = 1; mt[idx] = tg;
        return 1;
      end
    end
    if (mv[idx]) begin
      va[vp] = {mt[idx], a[IDX_W-1:0]};
      vv[vp] = 1;
      vp = (vp + 1) % VICT_N;
    end
    mv[idx] = 1; mt[idx] = tg;
    return 2;
  endfunction

  // memory: answers MEM_LAT cycles after it sees a request
  initial begin
    mem_resp_valid = 1'b0;
    mem_resp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        mem_last = mem_req_addr;
        repeat (MEM_LAT - 1) @(negedge clk);
        chk(mem_req_addr == mem_last, "R5", int'(mem_req_addr), int'(mem_last));
        mem_resp_valid = 1'b1;
        mem_resp_data  = memfn(mem_req_addr);
        mem_cnt++;
        @(negedge clk);
        mem_resp_valid = 1'b0;
      end
    end
  end

  // one access; src label names the requirement judged by the source code
  task automatic access(input logic [LINE_W-1:0] a, input string lbl);
    int exp, lat, mc0, exp_lat;
    exp = predict(a);
    mc0 = mem_cnt;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (exp != 0) chk(req_ready == 1'b0, "R8", int'(req_ready), 0);
    while (!resp_valid && lat < 100) begin @(negedge clk); lat++; end
    chk(resp_valid == 1'b1, lbl, int'(resp_valid), 1);
    chk(int'(resp_src) == exp, lbl, int'(resp_src), exp);
    chk(resp_data == memfn(a), (exp == 1) ? "R4" : "R5", int'(resp_data), int'(memfn(a)));
    exp_lat = (exp == 0) ? 1 : (exp == 1) ? 2 : 2 + MEM_LAT;
    chk(lat == exp_lat, (exp == 0) ? "R2" : "R3", lat, exp_lat);
    if (exp == 2) begin
      chk(mem_cnt == mc0 + 1 && mem_last == a, "R5", int'(mem_last), int'(a));
    end else begin
      chk(mem_cnt == mc0, "R2", mem_cnt, mc0);
    end
    chk(req_ready == 1'b1, "R10", int'(req_ready), 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [LINE_W-1:0] a;
    logic [15:0] lfsr;
    checks = 0; failures = 0; mem_cnt = 0; mem_last = '0;
    do_reset();
    // R1 reset state
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", int'(resp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1", int'(mem_req_valid), 0);

    // R7: cold fills of every set insert nothing; R1 first access from memory
    for (int i = 0; i < SETS; i++) access(LINE_W'(i), "R1");
    // R6/R9: displace sets 0..3 -> four lines from different sets in buffer
    for (int i = 0; i < VICT_N; i++) access(LINE_W'(SETS + i), "R6");
    for (int i = 0; i < VICT_N; i++) access(LINE_W'(i), "R9");
    // R4: swap ping-pong inside set 5
    access(LINE_W'(2*SETS + 5), "R5");
    for (int r = 0; r < 6; r++) begin
      access(LINE_W'(5), "R4");
      access(LINE_W'(2*SETS + 5), "R4");
    end
    // R10: immediate repeat after fill and after swap
    access(LINE_W'(3*SETS + 6), "R5");
    access(LINE_W'(3*SETS + 6), "R10");
    access(LINE_W'(6), "R3");
    access(LINE_W'(6), "R10");
    // R6: push more than VICT_N lines out of one set, oldest lost
    for (int t = 0; t < 8; t++) access(LINE_W'(t*SETS + 7), "R6");
    for (int t = 7; t >= 0; t--) access(LINE_W'(t*SETS + 7), "R6");

    // full sweeps, forward and reverse
    for (int i = 0; i < (1 << LINE_W); i++) access(LINE_W'(i), "R3");
    for (int i = (1 << LINE_W) - 1; i >= 0; i--) access(LINE_W'(i), "R3");

    // pseudo-random stream
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[LINE_W-1:0];
      if (n % 3 == 0) a[LINE_W-1] = 1'b0;
      access(a, "R3");
    end

    // R1: second reset forgets everything
    do_reset();
    chk(req_ready == 1'b1 && resp_valid == 1'b0, "R1", int'(resp_valid), 0);
    access(LINE_W'(0), "R1");
    access(LINE_W'(SETS), "R1");
    access(LINE_W'(0), "R3");

    finish_up();
  end
endmodule